// File: doc/BRIEF.md
# Whole-Array Erase Sequencer

This block drives an erase of the whole flash array. Software writes a two-cycle command: 30H and then D0H. The address bits play no part in this command. The block acts on it only when the shared erase engine is free. It then visits every block in ascending index order and passes over locked blocks without flagging them. Each unlocked block gets a fixed erase interval, and one completion pulse marks that the block now reads all ones.

Every partition keeps its own status register. An erase fault is written into all of them at once. Each error bit stays set until its own partition receives a clear-status command. While the erase runs, a read of any partition returns that partition's status byte. After the erase completes, each partition keeps returning its status until it is sent a read-array command. Once started, the erase cannot be suspended or disturbed by further commands.

Top module: `fce_chip_erase`

## Requirements
- R1: A 30H write followed by a D0H write starts the erase, whatever partition either write names, provided `engine_busy_other` is low when D0H is written. `erase_busy` is high from the cycle after the D0H write. If the engine is owned elsewhere, D0H has no effect.
- R2: The sequencer erases each unlocked block exactly once, in ascending index order, and never erases a locked block. `blk_done_vld` pulses once with `blk_done_idx` for each block it erased.
- R3: A locked block costs 1 busy cycle. An unlocked block costs 1 + ERASE_CYCLES busy cycles. With the defaults and no fault, busy lasts 8 + 4 × (number of unlocked blocks) cycles.
- R4: If every block is locked, no block is erased and `erase_busy` stays low. Every partition's status reads A2H, which is ready, erase error (bit 5) and lock error (bit 1).
- R5: If `vpp_ok` is low when D0H arrives, no block is erased. Every status reads A8H, which is ready, erase error (bit 5) and supply error (bit 3).
- R6: A 30H write followed by any byte other than D0H starts nothing. Every status reads B0H, which is ready, erase error (bit 5) and sequence error (bit 4).
- R7: When the erase of a block whose `err_inject` bit is set ends, the sequencer stops at once and leaves the later blocks unerased. Every status reads A0H.
- R8: Status bit 7 is 1 when the block is idle and 0 while it is busy. During an erase, and after one until FFH is written to a partition, a read of that partition gives {00H, status}. FFH returns only the named partition to array reads.
- R9: While busy, every command write is ignored, including a suspend byte (B0H), 50H, FFH and another 30H/D0H.
- R10: A 50H write clears the error bits of the named partition only.
- R11: After reset, every status reads 80H, reads return `array_rdata`, and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command byte |
| cmd_part | input | PART_W | Partition the write addresses |
| engine_busy_other | input | 1 | Erase engine owned by another partition |
| lock_bits | input | NUM_BLOCKS | Per-block lock flags |
| vpp_ok | input | 1 | Programming supply above lockout |
| err_inject | input | NUM_BLOCKS | Per-block erase fault injection for test |
| rd_part | input | PART_W | Partition being read |
| array_rdata | input | DATA_W | Array data for the read |
| rd_data | output | DATA_W | Read result: array data or status |
| status_flat | output | 8*NUM_PARTS | All status bytes, partition 0 in the low byte |
| erase_busy | output | 1 | Erase in progress |
| erase_active | output | 1 | A block is currently being erased |
| erase_blk | output | IDX_W | Block index being visited |
| blk_done_vld | output | 1 | One-cycle pulse: a block was erased |
| blk_done_idx | output | IDX_W | Index of that block |

## Verification
`erase_busy` rises on the clock edge that captures D0H. The supply, all-locked and sequence faults reach the status registers on that same edge, so the bench samples them at the following falling edge. A block's completion pulse appears on the edge that ends its erase interval. On an injected fault, the error bits and the fall of `erase_busy` arrive together on that edge. The bench samples at falling edges. It counts busy cycles and collects completion pulses in a monitor. It compares the totals with the cycle formula in R3 once `erase_busy` has dropped, rather than polling for results.

// File: rtl/fce_pkg.sv
package fce_pkg;

    localparam logic [7:0] OP_ERASE_ALL = 8'h30;
    localparam logic [7:0] OP_CONFIRM   = 8'hD0;
    localparam logic [7:0] OP_CLR_STAT  = 8'h50;
    localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_RD_STAT   = 8'h70;

    // sticky error flags held per partition
    typedef struct packed {
        logic erase_err;   // SR bit 5
        logic seq_err;     // SR bit 4
        logic supply_err;  // SR bit 3
        logic lock_err;    // SR bit 1
    } err_bits_t;

    typedef enum logic [1:0] {
        W_IDLE,
        W_SCAN,
        W_ERASE
    } walk_state_t;

    // decoded command events for one cycle
    typedef struct packed {
        logic go;
        logic bad_seq;
        logic clr;
        logic rd_array;
        logic rd_stat;
    } cmd_evt_t;

    function automatic logic [7:0] pack_sr(input logic ready, input err_bits_t e);
        return {ready, 1'b0, e.erase_err, e.seq_err, e.supply_err, 1'b0, e.lock_err, 1'b0};
    endfunction

    function automatic err_bits_t err_or(input err_bits_t a, input err_bits_t b);
        return err_bits_t'(a | b);
    endfunction

endpackage

// File: rtl/fce_cmd_decode.sv
module fce_cmd_decode
    import fce_pkg::*;
#(
    parameter int PART_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_data,
    input  logic [PART_W-1:0] cmd_part,
    input  logic              seq_busy,
    input  logic              engine_busy_other,
    output cmd_evt_t          evt,
    output logic [PART_W-1:0] evt_part
);

    logic armed;
    logic take;

    assign take     = cmd_we && !seq_busy;
    assign evt_part = cmd_part;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (take) begin
            armed <= !armed && (cmd_data == OP_ERASE_ALL);
        end
    end

    always_comb begin
        evt = '0;
        if (take) begin
            if (armed) begin
                if (cmd_data == OP_CONFIRM) begin
                    evt.go = !engine_busy_other;
                end else begin
                    evt.bad_seq = 1'b1;
                end
            end else begin
                case (cmd_data)
                    OP_CLR_STAT: evt.clr      = 1'b1;
                    OP_RD_ARRAY: evt.rd_array = 1'b1;
                    OP_RD_STAT:  evt.rd_stat  = 1'b1;
                    default:     evt          = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/fce_walker.sv
module fce_walker
    import fce_pkg::*;
#(
    parameter int NUM_BLOCKS   = 8,
    parameter int ERASE_CYCLES = 4,
    localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int CNT_W = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [NUM_BLOCKS-1:0] lock_bits,
    input  logic                  vpp_ok,
    input  logic [NUM_BLOCKS-1:0] err_inject,
    output logic                  busy,
    output logic                  erasing,
    output logic [IDX_W-1:0]      blk_idx,
    output logic                  done_vld,
    output logic [IDX_W-1:0]      done_idx,
    output err_bits_t             fault
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ERASE_CYCLES - 1);

    walk_state_t      state;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt;
    logic             all_locked;
    logic             at_last;
    logic             slot_end;

    assign all_locked = &lock_bits;
    assign at_last    = (idx == LAST_IDX);
    assign slot_end   = (state == W_ERASE) && (cnt == LAST_CNT);
    assign busy       = (state != W_IDLE);
    assign erasing    = (state == W_ERASE);
    assign blk_idx    = idx;

    always_comb begin
        fault = '0;
        if (state == W_IDLE && go) begin
            if (!vpp_ok) begin
                fault.erase_err  = 1'b1;
                fault.supply_err = 1'b1;
            end else if (all_locked) begin
                fault.erase_err = 1'b1;
                fault.lock_err  = 1'b1;
            end
        end
        if (slot_end && err_inject[idx]) begin
            fault.erase_err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= W_IDLE;
            idx      <= '0;
            cnt      <= '0;
            done_vld <= 1'b0;
            done_idx <= '0;
        end else begin
            done_vld <= 1'b0;
            case (state)
                W_IDLE: begin
                    if (go && vpp_ok && !all_locked) begin
                        state <= W_SCAN;
                        idx   <= '0;
                    end
                end
                W_SCAN: begin
                    if (lock_bits[idx]) begin
                        if (at_last) state <= W_IDLE;
                        else         idx   <= idx + 1'b1;
                    end else begin
                        state <= W_ERASE;
                        cnt   <= '0;
                    end
                end
                W_ERASE: begin
                    if (cnt == LAST_CNT) begin
                        if (err_inject[idx]) begin
                            state <= W_IDLE;
                        end else begin
                            done_vld <= 1'b1;
                            done_idx <= idx;
                            if (at_last) begin
                                state <= W_IDLE;
                            end else begin
                                idx   <= idx + 1'b1;
                                state <= W_SCAN;
                            end
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fce_status_bank.sv
module fce_status_bank
    import fce_pkg::*;
#(
    parameter int NUM_PARTS = 4,
    parameter int PART_W    = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  err_bits_t              set_mask,
    input  logic                   to_status_all,
    input  logic                   clr,
    input  logic                   rd_array,
    input  logic                   rd_stat,
    input  logic [PART_W-1:0]      part,
    input  logic                   ready,
    output logic [NUM_PARTS*8-1:0] sr_flat,
    output logic [NUM_PARTS-1:0]   stat_mode
);

    for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
        err_bits_t err_q;
        logic      hit;

        assign hit = (part == PART_W'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                err_q        <= '0;
                stat_mode[p] <= 1'b0;
            end else begin
                err_q <= err_or((clr && hit) ? err_bits_t'('0) : err_q, set_mask);
                if (to_status_all) begin
                    stat_mode[p] <= 1'b1;
                end else if (rd_array && hit) begin
                    stat_mode[p] <= 1'b0;
                end else if ((rd_stat || clr) && hit) begin
                    stat_mode[p] <= 1'b1;
                end
            end
        end

        assign sr_flat[p*8 +: 8] = pack_sr(ready, err_q);
    end

endmodule

// File: rtl/fce_chip_erase.sv
module fce_chip_erase
    import fce_pkg::*;
#(
    parameter int NUM_BLOCKS   = 8,
    parameter int NUM_PARTS    = 4,
    parameter int ERASE_CYCLES = 4,
    parameter int DATA_W       = 16,
    localparam int PART_W = (NUM_PARTS > 1) ? $clog2(NUM_PARTS) : 1,
    localparam int IDX_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_we,
    input  logic [7:0]             cmd_data,
    input  logic [PART_W-1:0]      cmd_part,
    input  logic                   engine_busy_other,
    input  logic [NUM_BLOCKS-1:0]  lock_bits,
    input  logic                   vpp_ok,
    input  logic [NUM_BLOCKS-1:0]  err_inject,
    input  logic [PART_W-1:0]      rd_part,
    input  logic [DATA_W-1:0]      array_rdata,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NUM_PARTS*8-1:0] status_flat,
    output logic                   erase_busy,
    output logic                   erase_active,
    output logic [IDX_W-1:0]       erase_blk,
    output logic                   blk_done_vld,
    output logic [IDX_W-1:0]       blk_done_idx
);

    cmd_evt_t            evt;
    logic [PART_W-1:0]   evt_part;
    err_bits_t           walk_fault;
    err_bits_t           seq_fault;
    err_bits_t           set_mask;
    logic [NUM_PARTS-1:0] stat_mode;
    logic [7:0]          sel_sr;
    logic                show_status;

    fce_cmd_decode #(.PART_W(PART_W)) u_dec (
        .clk               (clk),
        .rst               (rst),
        .cmd_we            (cmd_we),
        .cmd_data          (cmd_data),
        .cmd_part          (cmd_part),
        .seq_busy          (erase_busy),
        .engine_busy_other (engine_busy_other),
        .evt               (evt),
        .evt_part          (evt_part)
    );

    fce_walker #(
        .NUM_BLOCKS   (NUM_BLOCKS),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_walk (
        .clk        (clk),
        .rst        (rst),
        .go         (evt.go),
        .lock_bits  (lock_bits),
        .vpp_ok     (vpp_ok),
        .err_inject (err_inject),
        .busy       (erase_busy),
        .erasing    (erase_active),
        .blk_idx    (erase_blk),
        .done_vld   (blk_done_vld),
        .done_idx   (blk_done_idx),
        .fault      (walk_fault)
    );

    always_comb begin
        seq_fault           = '0;
        seq_fault.erase_err = evt.bad_seq;
        seq_fault.seq_err   = evt.bad_seq;
    end

    assign set_mask = err_or(walk_fault, seq_fault);

    fce_status_bank #(
        .NUM_PARTS (NUM_PARTS),
        .PART_W    (PART_W)
    ) u_stat (
        .clk           (clk),
        .rst           (rst),
        .set_mask      (set_mask),
        .to_status_all (evt.go || evt.bad_seq || (|set_mask)),
        .clr           (evt.clr),
        .rd_array      (evt.rd_array),
        .rd_stat       (evt.rd_stat),
        .part          (evt_part),
        .ready         (!erase_busy),
        .sr_flat       (status_flat),
        .stat_mode     (stat_mode)
    );

    assign sel_sr      = status_flat[rd_part*8 +: 8];
    assign show_status = erase_busy || stat_mode[rd_part];
    assign rd_data     = show_status ? DATA_W'(sel_sr) : array_rdata;

endmodule

// File: rtl/fce_chip_erase_chk.sv
module fce_chip_erase_chk #(
    parameter int NUM_BLOCKS = 8,
    parameter int NUM_PARTS  = 4,
    parameter int DATA_W     = 16,
    localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   engine_busy_other,
    input logic [NUM_BLOCKS-1:0]  lock_bits,
    input logic [DATA_W-1:0]      rd_data,
    input logic [NUM_PARTS*8-1:0] status_flat,
    input logic                   erase_busy,
    input logic                   erase_active,
    input logic [IDX_W-1:0]       erase_blk,
    input logic                   blk_done_vld,
    input logic [IDX_W-1:0]       blk_done_idx
);

    logic unused_status;
    assign unused_status = ^{status_flat, rd_data[6:0]};

    // R8
    sr7_low_first_chk: assert property (@(posedge clk) disable iff (rst)
        erase_busy |-> !status_flat[7]);

    // R8
    sr7_low_last_chk: assert property (@(posedge clk) disable iff (rst)
        erase_busy |-> !status_flat[NUM_PARTS*8-1]);

    // R8
    busy_reads_status_chk: assert property (@(posedge clk) disable iff (rst)
        erase_busy |-> (rd_data[DATA_W-1:7] == '0));

    // R2
    skip_locked_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(erase_active) |-> !$past(lock_bits[erase_blk]));

    // R2
    ascending_chk: assert property (@(posedge clk) disable iff (rst)
        (erase_busy && $past(erase_busy)) |-> (erase_blk >= $past(erase_blk)));

    // R2
    done_follows_erase_chk: assert property (@(posedge clk) disable iff (rst)
        blk_done_vld |-> ($past(erase_active) && ($past(erase_blk) == blk_done_idx)));

    // R1
    engine_owned_chk: assert property (@(posedge clk) disable iff (rst)
        (engine_busy_other && !erase_busy) |=> !erase_busy);

endmodule

bind fce_chip_erase fce_chip_erase_chk #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .NUM_PARTS  (NUM_PARTS),
    .DATA_W     (DATA_W)
) u_chk (
    .clk               (clk),
    .rst               (rst),
    .engine_busy_other (engine_busy_other),
    .lock_bits         (lock_bits),
    .rd_data           (rd_data),
    .status_flat       (status_flat),
    .erase_busy        (erase_busy),
    .erase_active      (erase_active),
    .erase_blk         (erase_blk),
    .blk_done_vld      (blk_done_vld),
    .blk_done_idx      (blk_done_idx)
);

// File: tb/fce_chip_erase_test.sv
`timescale 1ns/1ps
module fce_chip_erase_test;

    localparam int NB = 8;
    localparam int NP = 4;
    localparam int EC = 4;
    localparam int DW = 16;
    localparam logic [DW-1:0] ARR = 16'h5A3C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_we = 1'b0;
    logic [7:0]    cmd_data = '0;
    logic [1:0]    cmd_part = '0;
    logic          engine_busy_other = 1'b0;
    logic [NB-1:0] lock_bits = '0;
    logic          vpp_ok = 1'b1;
    logic [NB-1:0] err_inject = '0;
    logic [1:0]    rd_part = '0;
    logic [DW-1:0] array_rdata = ARR;
    logic [DW-1:0] rd_data;
    logic [NP*8-1:0] status_flat;
    logic          erase_busy;
    logic          erase_active;
    logic [2:0]    erase_blk;
    logic          blk_done_vld;
    logic [2:0]    blk_done_idx;

    int checks = 0;
    int fails = 0;
    int busy_cycles = 0;
    int order_err = 0;
    int seen = 0;
    int last_done = 0;
    logic [NB-1:0] erased = '0;

    always #4 clk = ~clk;

    fce_chip_erase #(.NUM_BLOCKS(NB), .NUM_PARTS(NP), .ERASE_CYCLES(EC), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data), .cmd_part(cmd_part),
        .engine_busy_other(engine_busy_other), .lock_bits(lock_bits), .vpp_ok(vpp_ok),
        .err_inject(err_inject), .rd_part(rd_part), .array_rdata(array_rdata),
        .rd_data(rd_data), .status_flat(status_flat), .erase_busy(erase_busy),
        .erase_active(erase_active), .erase_blk(erase_blk),
        .blk_done_vld(blk_done_vld), .blk_done_idx(blk_done_idx)
    );

    always @(negedge clk) begin
        if (erase_busy) busy_cycles++;
        if (blk_done_vld) begin
            if (seen != 0 && int'(blk_done_idx) <= last_done) order_err++;
            seen = 1;
            last_done = int'(blk_done_idx);
            erased[blk_done_idx] = 1'b1;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] p, input logic [7:0] d);
        @(negedge clk);
        cmd_we = 1'b1; cmd_data = d; cmd_part = p;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic clear_mon();
        busy_cycles = 0; order_err = 0; seen = 0; last_done = 0; erased = '0;
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 2000 && erase_busy; n++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_part(input logic [1:0] p, output logic [DW-1:0] v);
        rd_part = p;
        #1;
        v = rd_data;
    endtask

    task automatic check_all_sr(input string req, input logic [7:0] exp);
        for (int p = 0; p < NP; p++) check(req, 32'(status_flat[p*8 +: 8]), 32'(exp));
    endtask

    task automatic reset_all();
        for (int p = 0; p < NP; p++) begin
            wr(2'(p), 8'h50);
            wr(2'(p), 8'hFF);
        end
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        check_all_sr("R11 status", 8'h80);
        read_part(2'd0, v);
        check("R11 array read", 32'(v), 32'(ARR));
        check("R11 idle", 32'(erase_busy), 32'd0);
    endtask

    task automatic t_basic();
        logic [DW-1:0] v;
        lock_bits = 8'h24;
        clear_mon();
        wr(2'd0, 8'h30);
        wr(2'd2, 8'hD0);
        check("R1 busy after D0H", 32'(erase_busy), 32'd1);
        check("R8 SR7 low busy", 32'(status_flat[7]), 32'd0);
        wait_idle();
        check("R2 erased set", 32'(erased), 32'h0DB);
        check("R2 order", 32'(order_err), 32'd0);
        check("R3 busy cycles", 32'(busy_cycles), 32'd32);
        check_all_sr("R8 status done", 8'h80);
        read_part(2'd3, v);
        check("R8 status read", 32'(v), 32'h0080);
    endtask

    task automatic t_read_array();
        logic [DW-1:0] v;
        wr(2'd1, 8'hFF);
        read_part(2'd1, v);
        check("R8 FFH part1 array", 32'(v), 32'(ARR));
        read_part(2'd2, v);
        check("R8 part2 still status", 32'(v), 32'h0080);
        reset_all();
    endtask

    task automatic t_all_locked();
        lock_bits = '1;
        clear_mon();
        wr(2'd0, 8'h30);
        wr(2'd0, 8'hD0);
        check("R4 not busy", 32'(erase_busy), 32'd0);
        wait_idle();
        check("R4 nothing erased", 32'(erased), 32'd0);
        check_all_sr("R4 lock status", 8'hA2);
        lock_bits = '0;
    endtask

    task automatic t_clear_one();
        wr(2'd2, 8'h50);
        @(negedge clk);
        check("R10 part2 cleared", 32'(status_flat[23:16]), 32'h80);
        check("R10 part0 kept", 32'(status_flat[7:0]), 32'hA2);
        check("R10 part3 kept", 32'(status_flat[31:24]), 32'hA2);
        reset_all();
        check_all_sr("R10 all cleared", 8'h80);
    endtask

    task automatic t_vpp();
        vpp_ok = 1'b0;
        clear_mon();
        wr(2'd1, 8'h30);
        wr(2'd3, 8'hD0);
        wait_idle();
        check("R5 nothing erased", 32'(erased), 32'd0);
        check_all_sr("R5 supply status", 8'hA8);
        vpp_ok = 1'b1;
        reset_all();
    endtask

    task automatic t_bad_seq();
        logic [DW-1:0] v;
        clear_mon();
        wr(2'd0, 8'h30);
        wr(2'd0, 8'h40);
        @(negedge clk);
        check("R6 not busy", 32'(erase_busy), 32'd0);
        check_all_sr("R6 seq status", 8'hB0);
        read_part(2'd1, v);
        check("R6 status read", 32'(v), 32'h00B0);
        reset_all();
    endtask

    task automatic t_fault();
        err_inject = 8'h08;
        clear_mon();
        wr(2'd0, 8'h30);
        wr(2'd0, 8'hD0);
        wait_idle();
        check("R7 stopped at fault", 32'(erased), 32'h007);
        check("R7 busy cycles", 32'(busy_cycles), 32'd20);
        check_all_sr("R7 fault status", 8'hA0);
        err_inject = '0;
        reset_all();
    endtask

    task automatic t_engine_owned();
        engine_busy_other = 1'b1;
        clear_mon();
        wr(2'd0, 8'h30);
        wr(2'd0, 8'hD0);
        @(negedge clk);
        check("R1 no start when owned", 32'(busy_cycles), 32'd0);
        check_all_sr("R1 status untouched", 8'h80);
        engine_busy_other = 1'b0;
    endtask

    task automatic t_ignored();
        logic [DW-1:0] v;
        wr(2'd0, 8'h30);
        wr(2'd0, 8'h41);
        clear_mon();
        wr(2'd0, 8'h30);
        wr(2'd0, 8'hD0);
        wr(2'd0, 8'hB0);
        wr(2'd1, 8'h50);
        wr(2'd0, 8'hFF);
        wr(2'd0, 8'h30);
        wr(2'd0, 8'hD0);
        wait_idle();
        check("R9 full erase", 32'(erased), 32'h0FF);
        check("R9 busy cycles", 32'(busy_cycles), 32'd40);
        check_all_sr("R9 clear ignored", 8'hB0);
        read_part(2'd0, v);
        check("R9 FFH ignored", 32'(v), 32'h00B0);
        reset_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_read_array();
        t_all_locked();
        t_clear_one();
        t_vpp();
        t_bad_seq();
        t_fault();
        t_engine_owned();
        t_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule